// File: doc/BRIEF.md
# Preemptive Interrupt Priority Arbiter

This block decides which pending exception the processor should service next, and whether that exception may interrupt the handler that is running now. It watches a set of peripheral interrupt lines. Each line has a programmable priority. It also watches three system exceptions whose priority is fixed above every programmable level. Each input pulse marks its source pending. Every cycle the block reports the most urgent pending source. When that source's urgency beats the current execution level, the block raises a one-cycle preempt strobe and takes the source as the new active handler.

A grouping setting splits each priority value into a high group field and a low subpriority field. Only the group field counts when deciding preemption. The full value, and after it the exception number, orders the pending sources among themselves. A stack of active group levels keeps track of nested handlers. A completion strobe pops the stack. After that pop, a pending source that now outranks the restored level is taken on the next cycle. Otherwise execution returns to the interrupted context.

Exception numbering: reset is 1, the non-maskable interrupt is 2, hard fault is 3, and peripheral line i is 16+i. The index space used by the status vectors is: bit 0 for reset, bit 1 for the non-maskable interrupt, bit 2 for hard fault, and bit 3+i for line i.

Top module: `irq_prio_arb`

## Requirements
- R1: After a synchronous reset, every line priority is 0, grouping is 0, no source is pending or active, and sel_valid, sel_exc and preempt_req are 0.
- R2: A numerically lower priority value is more urgent. sel_valid/sel_exc show the most urgent pending source one clock after the pending state they are drawn from; sel_exc is 0 when nothing is pending.
- R3: Reset, then the non-maskable interrupt, then hard fault outrank every programmable line, in that order.
- R4: Among pending sources with equal priority value, the lowest exception number wins.
- R5: Grouping value g (0..7) makes the low min(g,4) bits of a priority the subpriority and the rest the group. Pending sources are ordered by group, then subpriority, then number.
- R6: preempt_req fires only when no handler is active or the winner's group level is strictly more urgent than the top of the active stack. A source with an equal group level stays pending.
- R7: With preempt_req, the accepted source's pending bit clears, its active bit sets, and sel_exc in that same cycle gives its number.
- R8: A done_valid cycle clears the active bit of done_exc, pops one stack level and blocks preemption in that cycle. Afterwards a pending source is taken only if it outranks the restored level.
- R9: A pulse sets the pending bit. A pulse that arrives in the cycle its source is accepted leaves the bit set.
- R10: The active stack never grows beyond three fixed levels plus one level per group value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pulse | input | NUM_IRQ | Request pulses, one per peripheral line |
| sys_pulse | input | 3 | Request pulses: bit0 reset, bit1 non-maskable, bit2 hard fault |
| prio_we | input | 1 | Priority write enable |
| prio_widx | input | IW | Line index for the priority write |
| prio_wdata | input | PRIO_W | Priority value written |
| grp_we | input | 1 | Grouping write enable |
| grp_wdata | input | 3 | Grouping value written |
| done_valid | input | 1 | Handler completion strobe |
| done_exc | input | 8 | Exception number of the completed handler |
| sel_valid | output | 1 | A source is pending |
| sel_exc | output | 8 | Exception number of the most urgent pending source |
| preempt_req | output | 1 | One-cycle strobe: sel_exc has been accepted as the active handler |
| pend_status | output | 3+NUM_IRQ | Pending bits, index order as above |
| act_status | output | 3+NUM_IRQ | Active bits, index order as above |

## Verification
The bench checks that an equal-priority arrival does not preempt while a strictly more urgent one does. A design that compared with less-or-equal would nest handlers of the same level. It checks that grouping hides the subpriority from preemption and still orders the pending queue by it. A design that compared full values would preempt within a group, and one that ignored the subpriority would pick the lower number first. It also covers the return path after completion and a pulse that arrives on the very cycle of acceptance. A design that got these wrong would take a too-weak source on return, or lose the repeated request.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int SYS_N    = 3;
  localparam int EXC_W    = 8;
  localparam int IRQ_BASE = 16;

  function automatic logic [EXC_W-1:0] idx2num(input logic [EXC_W-1:0] idx);
    if (idx < EXC_W'(SYS_N)) return idx + 8'd1;
    return idx + EXC_W'(IRQ_BASE - SYS_N);
  endfunction
endpackage

// File: rtl/irq_exc_state.sv
module irq_exc_state #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 4,
  parameter int NUM_EXC = 11,
  parameter int XW      = 4,
  parameter int IW      = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_EXC-1:0]         set_pend,
  input  logic                       accept,
  input  logic [XW-1:0]              acc_idx,
  input  logic                       done_hit,
  input  logic [XW-1:0]              done_idx,
  input  logic                       prio_we,
  input  logic [IW-1:0]              prio_widx,
  input  logic [PRIO_W-1:0]          prio_wdata,
  input  logic                       grp_we,
  input  logic [2:0]                 grp_wdata,
  output logic [NUM_EXC-1:0]         pend_q,
  output logic [NUM_EXC-1:0]         act_q,
  output logic [NUM_IRQ*PRIO_W-1:0]  prio_flat,
  output logic [2:0]                 grp_q
);
  logic [PRIO_W-1:0]  prio_q [NUM_IRQ];
  logic [NUM_EXC-1:0] pend_n, act_n;

  always_comb begin
    pend_n = pend_q;
    act_n  = act_q;
    if (done_hit) act_n[done_idx] = 1'b0;
    if (accept) begin
      pend_n[acc_idx] = 1'b0;
      act_n[acc_idx]  = 1'b1;
    end
    pend_n = pend_n | set_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
      grp_q  <= '0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
      if (grp_we) grp_q <= grp_wdata;
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) prio_q[g] <= '0;
      else if (prio_we && prio_widx == IW'(g)) prio_q[g] <= prio_wdata;
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  // R9: an accepted source must have been pending
  assert_accept_pending_R9: assert property (@(posedge clk) disable iff (rst)
    accept |-> pend_q[acc_idx]);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 4,
  parameter int NUM_EXC = 11,
  parameter int XW      = 4,
  parameter int LVL_W   = 5
) (
  input  logic [NUM_EXC-1:0]        pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  input  logic [2:0]                grp,
  output logic                      any,
  output logic [XW-1:0]             win_idx,
  output logic [LVL_W-1:0]          win_lvl
);
  import irq_arb_pkg::*;
  localparam int KEY_W = PRIO_W + 1;

  logic [PRIO_W-1:0] gmask;
  logic [KEY_W-1:0]  key [NUM_EXC];
  logic [LVL_W-1:0]  lvl [NUM_EXC];
  logic [KEY_W-1:0]  best;

  always_comb begin
    gmask = '1;
    for (int b = 0; b < PRIO_W; b++)
      if (b < int'(grp)) gmask[b] = 1'b0;
  end

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_key
    if (g < SYS_N) begin : g_fix
      assign key[g] = {1'b0, PRIO_W'(g)};
      assign lvl[g] = {1'b0, PRIO_W'(g)};
    end else begin : g_cfg
      logic [PRIO_W-1:0] p;
      assign p      = prio_flat[(g-SYS_N)*PRIO_W +: PRIO_W];
      assign key[g] = {1'b1, p};
      assign lvl[g] = {1'b1, p & gmask};
    end
  end

  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best    = '1;
    for (int i = 0; i < NUM_EXC; i++) begin
      if (pend[i] && (!any || key[i] < best)) begin
        any     = 1'b1;
        best    = key[i];
        win_idx = XW'(i);
      end
    end
  end

  assign win_lvl = lvl[win_idx];
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
  parameter int LVL_W = 5,
  parameter int DEPTH = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] top_lvl,
  output logic             empty
);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] mem [DEPTH];
  logic [SPW-1:0]   sp;

  assign empty   = (sp == '0);
  assign top_lvl = empty ? '1 : mem[sp - SPW'(1)];

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push && !pop) sp <= sp + SPW'(1);
    else if (pop && !push && !empty) sp <= sp - SPW'(1);
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    push |-> (sp < SPW'(DEPTH)));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_strict_push_R6: assert property (@(posedge clk) disable iff (rst)
    (push && !empty) |-> (push_lvl < top_lvl));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 4,
  parameter int IW      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_IRQ-1:0]     irq_pulse,
  input  logic [2:0]             sys_pulse,
  input  logic                   prio_we,
  input  logic [IW-1:0]          prio_widx,
  input  logic [PRIO_W-1:0]      prio_wdata,
  input  logic                   grp_we,
  input  logic [2:0]             grp_wdata,
  input  logic                   done_valid,
  input  logic [7:0]             done_exc,
  output logic                   sel_valid,
  output logic [7:0]             sel_exc,
  output logic                   preempt_req,
  output logic [NUM_IRQ+2:0]     pend_status,
  output logic [NUM_IRQ+2:0]     act_status
);
  import irq_arb_pkg::*;
  localparam int NUM_EXC = SYS_N + NUM_IRQ;
  localparam int XW      = $clog2(NUM_EXC);
  localparam int LVL_W   = PRIO_W + 1;
  localparam int DEPTH   = SYS_N + (1 << PRIO_W);

  logic [NUM_EXC-1:0]        pend_q, act_q;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic [2:0]                grp_q;
  logic                      any;
  logic [XW-1:0]             win_idx;
  logic [LVL_W-1:0]          win_lvl, top_lvl;
  logic                      stk_empty, accept;
  logic                      done_hit;
  logic [XW-1:0]             done_idx;
  logic [XW-1:0]             sel_idx_q;

  always_comb begin
    done_hit = 1'b0;
    done_idx = '0;
    if (done_exc >= 8'd1 && done_exc <= 8'(SYS_N)) begin
      done_hit = done_valid;
      done_idx = XW'(done_exc - 8'd1);
    end else if (done_exc >= 8'(IRQ_BASE) && done_exc < 8'(IRQ_BASE + NUM_IRQ)) begin
      done_hit = done_valid;
      done_idx = XW'(done_exc - 8'(IRQ_BASE - SYS_N));
    end
  end

  assign accept = any && !done_valid && (stk_empty || win_lvl < top_lvl);

  irq_exc_state #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .NUM_EXC(NUM_EXC),
                  .XW(XW), .IW(IW)) u_state (
    .clk(clk), .rst(rst),
    .set_pend({irq_pulse, sys_pulse}),
    .accept(accept), .acc_idx(win_idx),
    .done_hit(done_hit), .done_idx(done_idx),
    .prio_we(prio_we), .prio_widx(prio_widx), .prio_wdata(prio_wdata),
    .grp_we(grp_we), .grp_wdata(grp_wdata),
    .pend_q(pend_q), .act_q(act_q), .prio_flat(prio_flat), .grp_q(grp_q)
  );

  irq_prio_sel #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .NUM_EXC(NUM_EXC),
                 .XW(XW), .LVL_W(LVL_W)) u_sel (
    .pend(pend_q), .prio_flat(prio_flat), .grp(grp_q),
    .any(any), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_lvl_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push(accept), .push_lvl(win_lvl), .pop(done_valid),
    .top_lvl(top_lvl), .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid   <= 1'b0;
      sel_exc     <= '0;
      sel_idx_q   <= '0;
      preempt_req <= 1'b0;
    end else begin
      sel_valid   <= any;
      sel_exc     <= any ? idx2num(8'(win_idx)) : 8'd0;
      sel_idx_q   <= win_idx;
      preempt_req <= accept;
    end
  end

  assign pend_status = pend_q;
  assign act_status  = act_q;

  assert_accept_active_R7: assert property (@(posedge clk) disable iff (rst)
    preempt_req |-> act_q[sel_idx_q]);
  assert_done_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !preempt_req);
  assert_sys_first_R3: assert property (@(posedge clk) disable iff (rst)
    (|pend_q[SYS_N-1:0]) |=> (sel_valid && sel_idx_q < XW'(SYS_N)));
  assert_pend_seen_R2: assert property (@(posedge clk) disable iff (rst)
    (|pend_q) |=> sel_valid);
endmodule

// File: tb/irq_prio_arb_bench.sv
`timescale 1ns/1ps
module irq_prio_arb_bench;
  localparam int NUM_IRQ = 8;
  localparam int PRIO_W  = 4;
  localparam int IW      = 3;
  localparam int NUM_EXC = NUM_IRQ + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_IRQ-1:0] irq_pulse = '0;
  logic [2:0]  sys_pulse = '0;
  logic        prio_we = 1'b0;
  logic [IW-1:0] prio_widx = '0;
  logic [PRIO_W-1:0] prio_wdata = '0;
  logic        grp_we = 1'b0;
  logic [2:0]  grp_wdata = '0;
  logic        done_valid = 1'b0;
  logic [7:0]  done_exc = '0;
  logic        sel_valid, preempt_req;
  logic [7:0]  sel_exc;
  logic [NUM_EXC-1:0] pend_status, act_status;

  always #2 clk = ~clk;

  irq_prio_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_irq_prio_arb (
    .clk(clk), .rst(rst), .irq_pulse(irq_pulse), .sys_pulse(sys_pulse),
    .prio_we(prio_we), .prio_widx(prio_widx), .prio_wdata(prio_wdata),
    .grp_we(grp_we), .grp_wdata(grp_wdata), .done_valid(done_valid),
    .done_exc(done_exc), .sel_valid(sel_valid), .sel_exc(sel_exc),
    .preempt_req(preempt_req), .pend_status(pend_status), .act_status(act_status)
  );

  int vectors = 0;
  int fails   = 0;

  // reference state
  bit m_pend [NUM_EXC];
  bit m_act  [NUM_EXC];
  int m_prio [NUM_IRQ];
  int m_grp;
  int m_lvl  [32];
  int m_exc  [32];
  int msp;
  int exp_valid, exp_exc, exp_pre;

  function automatic int mkey(int i);
    return (i < 3) ? i : 16 + m_prio[i-3];
  endfunction
  function automatic int mlvl(int i);
    int sb, msk;
    if (i < 3) return i;
    sb  = (m_grp > PRIO_W) ? PRIO_W : m_grp;
    msk = 15 & ~((1 << sb) - 1);
    return 16 + (m_prio[i-3] & msk);
  endfunction
  function automatic int mnum(int i);
    return (i < 3) ? i + 1 : i + 13;
  endfunction
  function automatic int midx(int n);
    if (n >= 1 && n <= 3) return n - 1;
    if (n >= 16 && n < 16 + NUM_IRQ) return n - 13;
    return -1;
  endfunction

  task automatic chk(int got, int exp, string tag);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic model_step();
    bit an = 0; int w = 0; int bk = 0; int lv; int di;
    for (int i = 0; i < NUM_EXC; i++)
      if (m_pend[i] && (!an || mkey(i) < bk)) begin an = 1; bk = mkey(i); w = i; end
    exp_valid = an;
    exp_exc   = an ? mnum(w) : 0;
    lv        = mlvl(w);
    exp_pre   = an && !done_valid && (msp == 0 || lv < m_lvl[msp-1]);
    if (done_valid) begin
      di = midx(int'(done_exc));
      if (di >= 0) m_act[di] = 0;
      if (msp > 0) msp--;
    end
    if (exp_pre) begin
      m_pend[w] = 0; m_act[w] = 1;
      m_lvl[msp] = lv; m_exc[msp] = mnum(w); msp++;
    end
    for (int i = 0; i < 3; i++) if (sys_pulse[i]) m_pend[i] = 1;
    for (int i = 0; i < NUM_IRQ; i++) if (irq_pulse[i]) m_pend[i+3] = 1;
    if (prio_we) m_prio[prio_widx] = int'(prio_wdata);
    if (grp_we) m_grp = int'(grp_wdata);
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(int'(sel_valid), exp_valid, "R2 sel_valid");
    chk(int'(sel_exc), exp_exc, "R2 sel_exc");
    chk(int'(preempt_req), exp_pre, "R6 preempt_req");
    for (int i = 0; i < NUM_EXC; i++) begin
      chk(int'(pend_status[i]), int'(m_pend[i]), "R9 pend_status");
      chk(int'(act_status[i]), int'(m_act[i]), "R7 act_status");
    end
    irq_pulse = '0; sys_pulse = '0; prio_we = 0; grp_we = 0; done_valid = 0;
  endtask

  task automatic wprio(int idx, int v);
    prio_we = 1; prio_widx = IW'(idx); prio_wdata = PRIO_W'(v); cyc();
  endtask

  task automatic drain();
    for (int k = 0; k < 40; k++) begin
      if (msp > 0) begin done_valid = 1; done_exc = 8'(m_exc[msp-1]); end
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 got=hang exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < NUM_EXC; i++) begin m_pend[i] = 0; m_act[i] = 0; end
    for (int i = 0; i < NUM_IRQ; i++) m_prio[i] = 0;
    m_grp = 0; msp = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(int'(sel_valid), 0, "R1 sel_valid after reset");
    chk(int'(sel_exc), 0, "R1 sel_exc after reset");
    chk(int'(preempt_req), 0, "R1 preempt_req after reset");
    chk(int'(pend_status), 0, "R1 pend_status after reset");
    chk(int'(act_status), 0, "R1 act_status after reset");
    // R1/R4: reset priority 0 on both lines, lower number wins
    irq_pulse = 8'hC0; cyc(); cyc();
    chk(int'(sel_exc), 22, "R1 R4 reset priority tie");
    chk(int'(preempt_req), 1, "R1 thread accepts");
    drain();

    // R4/R7: equal priority 5 on lines 0 and 1
    wprio(0, 5); wprio(1, 5); wprio(2, 3);
    irq_pulse = 8'h03; cyc(); cyc();
    chk(int'(preempt_req), 1, "R7 accept strobe");
    chk(int'(sel_exc), 16, "R4 lowest number first");
    chk(int'(act_status[3]), 1, "R7 active set");
    cyc();
    chk(int'(preempt_req), 0, "R6 equal priority no preempt");
    chk(int'(pend_status[4]), 1, "R6 equal priority stays pending");
    chk(int'(sel_exc), 17, "R6 equal waits");
    // R2: more urgent line nests
    irq_pulse = 8'h04; cyc(); cyc();
    chk(int'(sel_exc), 18, "R2 lower value wins");
    chk(int'(preempt_req), 1, "R2 strictly higher preempts");
    // R3: non-maskable outranks
    sys_pulse = 3'b010; cyc(); cyc();
    chk(int'(sel_exc), 2, "R3 fixed outranks");
    chk(int'(preempt_req), 1, "R3 fixed preempts");
    // R8: unwind
    done_valid = 1; done_exc = 8'd2; cyc();
    chk(int'(act_status[1]), 0, "R8 active clears");
    cyc();
    chk(int'(preempt_req), 0, "R8 restored level blocks weaker");
    done_valid = 1; done_exc = 8'd18; cyc(); cyc();
    chk(int'(preempt_req), 0, "R8 equal level after pop");
    done_valid = 1; done_exc = 8'd16; cyc();
    chk(int'(preempt_req), 0, "R8 no preempt on done cycle");
    irq_pulse = 8'h02; cyc();
    chk(int'(preempt_req), 1, "R8 pending taken after return");
    chk(int'(sel_exc), 17, "R8 pending selection");
    chk(int'(pend_status[4]), 1, "R9 pulse on accept keeps pending");
    drain();

    // R5: grouping 2 -> groups of four values
    grp_we = 1; grp_wdata = 3'd2; cyc();
    wprio(3, 6); wprio(4, 5); wprio(5, 4);
    irq_pulse = 8'h08; cyc(); cyc();
    chk(int'(preempt_req), 1, "R5 first in group accepted");
    irq_pulse = 8'h30; cyc(); cyc();
    chk(int'(preempt_req), 0, "R5 same group no preempt");
    chk(int'(sel_exc), 21, "R5 subpriority orders pending");
    done_valid = 1; done_exc = 8'd19; cyc(); cyc();
    chk(int'(sel_exc), 21, "R5 subpriority taken first");
    chk(int'(preempt_req), 1, "R8 return to empty takes pending");
    drain();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NUM_IRQ; i++) irq_pulse[i] = (($urandom % 10) == 0);
      for (int i = 0; i < 3; i++) sys_pulse[i] = (($urandom % 80) == 0);
      if (($urandom % 8) == 0) begin
        prio_we = 1; prio_widx = IW'($urandom % NUM_IRQ); prio_wdata = PRIO_W'($urandom % 16);
      end
      if (($urandom % 40) == 0) begin grp_we = 1; grp_wdata = 3'($urandom % 8); end
      if (msp > 0 && ($urandom % 4) == 0) begin
        done_valid = 1; done_exc = 8'(m_exc[msp-1]);
      end
      cyc();
    end
    drain();
    chk(msp, 0, "R10 stack drained");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule